// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block listens to the clock and data lines of a two-wire open-drain serial bus and tells its neighbours when a transfer opens, reopens or closes. It only observes and never drives either line. A local master uses the busy level to hold back while another master owns the bus. A local slave uses the start and repeated-start pulses to restart its address matching.

Both lines pass through a chain of synchronizer flops. Each new synchronized sample is then compared with the one before it. A falling data line while the clock stays high opens a transfer. A rising data line while the clock stays high closes it. An opening seen while the bus is already owned is reported on a separate output, and the busy level does not drop.

There is no data stream through this block, so it has no valid/ready handshake. Every output is a plain control or status pin and cannot be back-pressured.

Top module: `i2c_bus_watch`

## Requirements
- R1: Each line passes through SYNC_STAGES flops (at least 2). An event output or a busy change appears SYNC_STAGES+1 clock cycles after the line change that caused it.
- R2: A start is a change of SDA from 1 to 0 between two consecutive synchronized samples, with SCL at 1 in both samples. If the bus is idle, start_o pulses high for one cycle and busy_o goes to 1 in that same cycle.
- R3: A stop is a change of SDA from 0 to 1 between two consecutive samples, with SCL at 1 in both. It pulses stop_o for one cycle, and busy_o is 0 from that cycle on. A stop seen while idle still pulses stop_o, and busy_o stays 0.
- R4: A start seen while busy_o is 1 pulses rstart_o instead of start_o, and busy_o stays 1.
- R5: busy_o rises only in a cycle in which start_o is high. It falls only in a cycle in which stop_o is high.
- R6: An SDA change in the same sample as an SCL change, in either direction, produces no event and leaves busy_o unchanged.
- R7: Reset (rst_n low) clears busy_o and all pulses. It presets the synchronizers and the previous-sample registers to 1, so an idle bus at release produces no event.
- R8: In any cycle at most one of start_o, rstart_o and stop_o is high, and no pulse lasts two cycles.
- R9: An SDA change while SCL stays 0 in both samples, which is an ordinary data bit, produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, asynchronous to the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| start_o | output | 1 | One-cycle pulse for a start on an idle bus |
| rstart_o | output | 1 | One-cycle pulse for a start on a busy bus |
| stop_o | output | 1 | One-cycle pulse for a stop |
| busy_o | output | 1 | Bus owned, from start until stop |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. It derives the expected latency of three cycles from that value, and checks every output in every cycle against a model delayed by that amount. At this depth, input patterns held for a single cycle reach the detector unchanged. Random line changes held for one to four cycles therefore produce back-to-back starts, repeated starts, idle stops and simultaneous line changes. Directed sequences add a full transfer with data bits, an SCL edge and an SDA edge in the same sample, and a reset in the middle of a transfer.

// File: rtl/bus_watch_pkg.sv
package bus_watch_pkg;
  typedef struct packed {
    logic scl;
    logic sda;
  } line_pair_t;

  typedef struct packed {
    logic open_seen;   // SDA fell with SCL held high
    logic close_seen;  // SDA rose with SCL held high
  } cond_t;

  localparam int unsigned MIN_SYNC = 2;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar ln = 0; ln < WIDTH; ln++) begin : g_line
    logic [STAGES-1:0] chain;
    for (genvar st = 0; st < STAGES; st++) begin : g_stage
      if (st == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[st] <= 1'b1;
          else        chain[st] <= raw_i[ln];
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[st] <= 1'b1;
          else        chain[st] <= chain[st-1];
        end
      end
    end
    assign sync_o[ln] = chain[STAGES-1];
  end
endmodule

// File: rtl/edge_classify.sv
module edge_classify
  import bus_watch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  line_pair_t cur_i,
  output cond_t      cond_o
);
  line_pair_t prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
    else        prev_q <= cur_i;
  end

  logic scl_steady_hi;
  assign scl_steady_hi = prev_q.scl & cur_i.scl;

  always_comb begin
    cond_o.open_seen  = scl_steady_hi & prev_q.sda & ~cur_i.sda;
    cond_o.close_seen = scl_steady_hi & ~prev_q.sda & cur_i.sda;
  end
endmodule

// File: rtl/bus_state_track.sv
module bus_state_track
  import bus_watch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  cond_t cond_i,
  output logic  start_o,
  output logic  rstart_o,
  output logic  stop_o,
  output logic  busy_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_o  <= 1'b0;
      rstart_o <= 1'b0;
      stop_o   <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      start_o  <= cond_i.open_seen & ~busy_o;
      rstart_o <= cond_i.open_seen & busy_o;
      stop_o   <= cond_i.close_seen;
      if (cond_i.close_seen)     busy_o <= 1'b0;
      else if (cond_i.open_seen) busy_o <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import bus_watch_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic rstart_o,
  output logic stop_o,
  output logic busy_o
);
  localparam int unsigned DEPTH = (SYNC_STAGES < MIN_SYNC) ? MIN_SYNC : SYNC_STAGES;

  logic [1:0] synced;
  line_pair_t cur;
  cond_t      cond;

  line_sync #(.STAGES(DEPTH), .WIDTH(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({scl_i, sda_i}),
    .sync_o (synced)
  );

  assign cur = '{scl: synced[1], sda: synced[0]};

  edge_classify u_cls (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_i  (cur),
    .cond_o (cond)
  );

  bus_state_track u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond_i   (cond),
    .start_o  (start_o),
    .rstart_o (rstart_o),
    .stop_o   (stop_o),
    .busy_o   (busy_o)
  );
endmodule

// File: rtl/bus_watch_checker.sv
module bus_watch_checker (
  input logic clk,
  input logic rst_n,
  input logic start_o,
  input logic rstart_o,
  input logic stop_o,
  input logic busy_o
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (busy_o && !$past(busy_o))); // R2
  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> !busy_o); // R3
  AST_RSTART_WHILE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_o |-> ($past(busy_o) && busy_o)); // R4
  AST_BUSY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> start_o); // R5
  AST_BUSY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> stop_o); // R5
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, rstart_o, stop_o})); // R8
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o || rstart_o) |=> !(start_o || rstart_o)); // R8
  AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !$past(rst_n) && !rst_n |-> !(busy_o || start_o || rstart_o || stop_o)); // R7
endmodule

bind i2c_bus_watch bus_watch_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_o  (start_o),
  .rstart_o (rstart_o),
  .stop_o   (stop_o),
  .busy_o   (busy_o)
);

// File: tb/tb_i2c_bus_watch.sv
module tb_i2c_bus_watch;
  localparam int unsigned STAGES = 2;
  localparam int unsigned LAT    = STAGES + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1;
  logic sda_i = 1'b1;
  logic start_o, rstart_o, stop_o, busy_o;

  int unsigned total = 0;
  int unsigned bad = 0;

  typedef struct packed { logic st; logic rs; logic sp; logic bz; } exp_t;
  exp_t pipe [LAT];
  logic m_busy;
  logic m_scl, m_sda;

  i2c_bus_watch #(.SYNC_STAGES(STAGES)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o), .busy_o(busy_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input logic act, input logic expv, input string req);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, expv);
    end
  endtask

  function automatic exp_t model(input logic ps, input logic pd, input logic cs,
                                 input logic cd, inout logic bsy);
    exp_t e;
    logic hi, opn, cls;
    hi  = ps & cs;                   // R6/R9: SCL must stay high across both samples
    opn = hi & pd & ~cd;
    cls = hi & ~pd & cd;
    e.st = opn & ~bsy;               // R2
    e.rs = opn & bsy;                // R4
    e.sp = cls;                      // R3
    if (cls) bsy = 1'b0;
    else if (opn) bsy = 1'b1;        // R5
    e.bz = bsy;
    return e;
  endfunction

  task automatic init_model();
    for (int i = 0; i < LAT; i++) pipe[i] = '0;
    m_busy = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
  endtask

  // R1: each transition's effect is checked exactly LAT cycles later
  task automatic step(input logic c, input logic d);
    exp_t n;
    @(negedge clk);
    chk(start_o,  pipe[0].st, "R2");
    chk(rstart_o, pipe[0].rs, "R4");
    chk(stop_o,   pipe[0].sp, "R3");
    chk(busy_o,   pipe[0].bz, "R5");
    for (int i = 0; i < LAT-1; i++) pipe[i] = pipe[i+1];
    n = model(m_scl, m_sda, c, d, m_busy);
    pipe[LAT-1] = n;
    m_scl = c; m_sda = d;
    scl_i = c; sda_i = d;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) step(m_scl, m_sda);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; scl_i = 1'b1; sda_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy_o, 1'b0, "R7");
    chk(start_o | rstart_o | stop_o, 1'b0, "R7");
    rst_n = 1'b1;
    init_model();
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    init_model();
    do_reset();
    hold(4);
    chk(busy_o, 1'b0, "R7");

    // Directed: full transfer with data bits, repeated start, stop (R2 R9 R4 R3)
    step(1, 0); hold(3);
    step(0, 0); step(0, 1); step(1, 1); step(0, 1); step(0, 0); step(1, 0); step(0, 0);
    step(0, 1); step(1, 1); hold(2);
    step(1, 0); hold(3);            // repeated start
    step(0, 0); step(1, 0); hold(1);
    step(1, 1); hold(4);            // stop
    chk(busy_o, 1'b0, "R3");

    // Directed: stop seen while idle (R3)
    step(0, 0); step(1, 0); step(1, 1); hold(4);

    // Directed: SDA and SCL change in the same sample (R6)
    step(0, 1); step(1, 0); hold(1); step(0, 1); step(1, 0); hold(4);
    step(1, 0); hold(1);            // start (sda already 0? no: held 0 -> no event)
    step(1, 1); step(0, 0); hold(4); // rise with SCL high -> stop, then both fall together
    step(1, 1); step(1, 0); hold(4); // real start
    step(0, 1); hold(1); step(1, 0); hold(4); // simultaneous: busy must stay
    chk(busy_o, 1'b1, "R6");

    // Reset in the middle of a transfer (R7)
    do_reset();
    hold(5);
    chk(busy_o, 1'b0, "R7");

    // Random line activity, held 1..4 cycles (R1..R9)
    for (int k = 0; k < 3000; k++) begin
      logic c, d;
      c = 1'($urandom_range(0, 1));
      d = 1'($urandom_range(0, 1));
      step(c, d);
      hold(int'($urandom_range(0, 3)));
    end
    hold(LAT + 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule